// File: doc/BRIEF.md
# Dual Wiper and Comparator-Control Register Bank

This block holds the settings of two digitally trimmed resistor wipers and two comparator control words. Each of the four targets owns one working register, which drives the hardware, and four stored registers, which keep settings for later recall. A serial front end decodes host traffic into single-cycle commands on `cmd_*`. The bank applies them: it reads and writes working and stored registers, copies a stored register into a working register (or the reverse) for one target or for all four at once, and moves a wiper up or down one tap at a time.

Writes into the stored registers behave like nonvolatile programming. They are captured when the command arrives and committed only after a busy window of `BUSY_CYCLES` clocks. During that window a busy flag is raised and can be polled through a status read. A write-protect input blocks every such write. After reset, each working register is recalled from stored register 0 of its own target.

The outputs are two wiper codes and their one-hot tap selects. For each comparator there is a power bit, an output-enable bit and a registered output that can be frozen.

Top module: `trim_regbank`

## Requirements
- R1: Target index 0 and 1 are the wipers and 2 and 3 are the comparator controls. After reset, stored register r of target t holds 8*t+2*r+1, and one clock after reset each working register equals its own stored register 0. Commands are ignored in that clock.
- R2: Op 0x2 writes `cmd_data` into working register `cmd_tgt`. Op 0x1 reads it back: `rd_valid` goes high with the value on `rd_data` after the next clock edge.
- R3: `tap_sel0` and `tap_sel1` are one-hot, with the set bit at the index equal to the matching wiper code. Code 0 is the low-end tap and code 63 is the high-end tap.
- R4: Op 0x9 moves wiper `cmd_tgt` (0 or 1) up one tap when `cmd_data[0]`=1 and down one tap when it is 0. Stepping up at 63 or down at 0 leaves the code unchanged. The op has no effect on targets 2 and 3.
- R5: Op 0x4 writes `cmd_data` into stored register (`cmd_tgt`,`cmd_reg`). `busy` is high for exactly `BUSY_CYCLES` clocks, and the new value becomes readable (op 0x3) only when `busy` falls. Reads during the window return the old value.
- R6: While `wp_n` is low, ops 0x4, 0x6 and 0x8 raise no busy window and change no stored register.
- R7: While `busy` is high, any further op 0x4, 0x6 or 0x8 is dropped.
- R8: Op 0x5 copies stored register (`cmd_tgt`,`cmd_reg`) into working register `cmd_tgt` at once. Op 0x6 copies working register `cmd_tgt` into that stored register through the busy window of R5.
- R9: Op 0x7 loads every working register from its own stored register `cmd_reg`. Op 0x8 saves every working register into its own stored register `cmd_reg` through one busy window.
- R10: Op 0xA returns a status word on `rd_data` whose bit 0 is `busy`; all other bits are 0.
- R11: In a comparator control word, bit 0 drives `cmp_pwr`, bit 1 drives `cmp_oe` and bit 2 is the hold bit. When the hold bit is 0, `cmp_out` takes `cmp_in` one clock later. When it is 1, `cmp_out` keeps its value. Comparator c uses target 2+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write protect for stored registers, active low |
| cmd_valid | input | 1 | One decoded command this cycle |
| cmd_op | input | 4 | Command code |
| cmd_tgt | input | 2 | Target index |
| cmd_reg | input | 2 | Stored-register index |
| cmd_data | input | DATA_W | Write data, or step direction in bit 0 |
| rd_valid | output | 1 | Read result present |
| rd_data | output | DATA_W | Read result |
| busy | output | 1 | Stored-register write in progress |
| wiper0_code | output | WIPER_W | Wiper 0 position |
| wiper1_code | output | WIPER_W | Wiper 1 position |
| tap_sel0 | output | 2**WIPER_W | One-hot tap select, wiper 0 |
| tap_sel1 | output | 2**WIPER_W | One-hot tap select, wiper 1 |
| cmp_in | input | 2 | Raw comparator decisions |
| cmp_out | output | 2 | Held or followed comparator outputs |
| cmp_oe | output | 2 | Comparator output enables |
| cmp_pwr | output | 2 | Comparator power controls |

## Verification
The bench steps each wiper into both rails. A counter that wraps would show 0 after stepping up from 63, and that would surface both on the read and on the tap select. It measures the busy window cycle by cycle and reads the target register inside the window. A design that commits early, or that lets the window run one clock long or short, fails there. It also issues stored writes under write protect and during a busy window; a design that honoured either would change the value read back afterwards. Finally it releases the comparator hold bit. A design that used the new hold bit in the same clock would let `cmp_out` follow `cmp_in` one cycle early.

// File: rtl/trim_pkg.sv
package trim_pkg;
   localparam int NUM_TGT   = 4;
   localparam int NUM_DR    = 4;
   localparam int ACR_PWR   = 0;
   localparam int ACR_EN    = 1;
   localparam int ACR_LATCH = 2;

   typedef enum logic [3:0] {
      OP_NOP     = 4'h0,
      OP_RD_WORK = 4'h1,
      OP_WR_WORK = 4'h2,
      OP_RD_DR   = 4'h3,
      OP_WR_DR   = 4'h4,
      OP_LOAD    = 4'h5,
      OP_SAVE    = 4'h6,
      OP_GLOAD   = 4'h7,
      OP_GSAVE   = 4'h8,
      OP_STEP    = 4'h9,
      OP_STATUS  = 4'hA
   } op_e;

   // reset image of the stored registers (R1)
   function automatic int dr_reset_val(int t, int r);
      return 8 * t + 2 * r + 1;
   endfunction
endpackage

// File: rtl/trim_tap_decoder.sv
module trim_tap_decoder #(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0]      code,
   output logic [(1<<CODE_W)-1:0] sel
);
   localparam int TAPS = 1 << CODE_W;

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign sel[i] = (code == CODE_W'(i));
   end
endmodule

// File: rtl/trim_nv_timer.sv
module trim_nv_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         cnt_q <= CW'(CYCLES - 1);
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/trim_cmp_channel.sv
module trim_cmp_channel (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic en_bit,
   input  logic pwr_bit,
   input  logic cmp_in,
   output logic cmp_out,
   output logic oe,
   output logic pwr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_out <= 1'b0;
      else if (!hold) cmp_out <= cmp_in;
   end

   assign oe  = en_bit;
   assign pwr = pwr_bit;
endmodule

// File: rtl/trim_regbank.sv
module trim_regbank
   import trim_pkg::*;
#(
   parameter int DATA_W      = 6,
   parameter int WIPER_W     = 6,
   parameter int BUSY_CYCLES = 500000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wp_n,
   input  logic                    cmd_valid,
   input  logic [3:0]              cmd_op,
   input  logic [1:0]              cmd_tgt,
   input  logic [1:0]              cmd_reg,
   input  logic [DATA_W-1:0]       cmd_data,
   output logic                    rd_valid,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    busy,
   output logic [WIPER_W-1:0]      wiper0_code,
   output logic [WIPER_W-1:0]      wiper1_code,
   output logic [(1<<WIPER_W)-1:0] tap_sel0,
   output logic [(1<<WIPER_W)-1:0] tap_sel1,
   input  logic [1:0]              cmp_in,
   output logic [1:0]              cmp_out,
   output logic [1:0]              cmp_oe,
   output logic [1:0]              cmp_pwr
);
   localparam int TAPS = 1 << WIPER_W;
   localparam logic [DATA_W-1:0] WMAX = DATA_W'(TAPS - 1);

   if (DATA_W < 3) begin : g_bad_dw
      $error("DATA_W must hold the three comparator control bits");
   end
   if (WIPER_W > DATA_W) begin : g_bad_ww
      $error("WIPER_W must not exceed DATA_W");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic [NUM_TGT-1:0][DATA_W-1:0]             work_q;
   logic [NUM_TGT-1:0][NUM_DR-1:0][DATA_W-1:0] dr_q;
   logic                                       recalled_q;
   logic [NUM_TGT-1:0]                         pend_mask_q;
   logic [1:0]                                 pend_reg_q;
   logic [NUM_TGT-1:0][DATA_W-1:0]             pend_data_q;
   op_e  op;
   logic live, nv_go, commit;

   assign op    = op_e'(cmd_op);
   assign live  = cmd_valid && recalled_q;
   assign nv_go = live && wp_n && !busy &&
                  (op == OP_WR_DR || op == OP_SAVE || op == OP_GSAVE);

   function automatic logic [DATA_W-1:0] step_sat(input logic [DATA_W-1:0] v,
                                                  input logic up);
      if (up) return (v >= WMAX) ? v : v + 1'b1;
      return (v == '0) ? v : v - 1'b1;
   endfunction

   // working registers: recall, direct write, transfers, steps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q     <= '0;
         recalled_q <= 1'b0;
      end else if (!recalled_q) begin
         for (int t = 0; t < NUM_TGT; t++) work_q[t] <= dr_q[t][0];
         recalled_q <= 1'b1;
      end else if (live) begin
         case (op)
            OP_WR_WORK: work_q[cmd_tgt] <= cmd_data;
            OP_LOAD:    work_q[cmd_tgt] <= dr_q[cmd_tgt][cmd_reg];
            OP_GLOAD:   for (int t = 0; t < NUM_TGT; t++) work_q[t] <= dr_q[t][cmd_reg];
            OP_STEP:    if (!cmd_tgt[1])
                           work_q[cmd_tgt] <= step_sat(work_q[cmd_tgt], cmd_data[0]);
            default: ;
         endcase
      end
   end

   // snapshot of a stored-register write, held until commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mask_q <= '0;
         pend_reg_q  <= '0;
         pend_data_q <= '0;
      end else if (nv_go) begin
         pend_reg_q <= cmd_reg;
         for (int t = 0; t < NUM_TGT; t++) begin
            pend_mask_q[t] <= (op == OP_GSAVE) || (cmd_tgt == 2'(t));
            pend_data_q[t] <= (op == OP_WR_DR) ? cmd_data : work_q[t];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < NUM_TGT; t++)
            for (int r = 0; r < NUM_DR; r++)
               dr_q[t][r] <= DATA_W'(dr_reset_val(t, r));
      end else if (commit) begin
         for (int t = 0; t < NUM_TGT; t++)
            if (pend_mask_q[t]) dr_q[t][pend_reg_q] <= pend_data_q[t];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= live && (op == OP_RD_WORK || op == OP_RD_DR || op == OP_STATUS);
         if (live) begin
            case (op)
               OP_RD_WORK: rd_data <= work_q[cmd_tgt];
               OP_RD_DR:   rd_data <= dr_q[cmd_tgt][cmd_reg];
               OP_STATUS:  rd_data <= DATA_W'(busy);
               default: ;
            endcase
         end
      end
   end

   trim_nv_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(nv_go), .busy(busy), .done(commit)
   );

   assign wiper0_code = work_q[0][WIPER_W-1:0];
   assign wiper1_code = work_q[1][WIPER_W-1:0];

   trim_tap_decoder #(.CODE_W(WIPER_W)) u_tap0 (.code(wiper0_code), .sel(tap_sel0));
   trim_tap_decoder #(.CODE_W(WIPER_W)) u_tap1 (.code(wiper1_code), .sel(tap_sel1));

   for (genvar c = 0; c < 2; c++) begin : g_cmp
      trim_cmp_channel u_cmp (
         .clk(clk), .rst_n(rst_n),
         .hold(work_q[2+c][ACR_LATCH]),
         .en_bit(work_q[2+c][ACR_EN]),
         .pwr_bit(work_q[2+c][ACR_PWR]),
         .cmp_in(cmp_in[c]),
         .cmp_out(cmp_out[c]),
         .oe(cmp_oe[c]),
         .pwr(cmp_pwr[c])
      );
   end
endmodule

// File: rtl/trim_regbank_chk.sv
module trim_regbank_chk
   import trim_pkg::*;
#(
   parameter int DATA_W  = 6,
   parameter int WIPER_W = 6
) (
   input logic                                       clk,
   input logic                                       rst_n,
   input logic                                       wp_n,
   input logic                                       cmd_valid,
   input logic [3:0]                                 cmd_op,
   input logic [1:0]                                 cmd_tgt,
   input logic [DATA_W-1:0]                          cmd_data,
   input logic                                       busy,
   input logic [WIPER_W-1:0]                         wiper0_code,
   input logic [WIPER_W-1:0]                         wiper1_code,
   input logic [(1<<WIPER_W)-1:0]                    tap_sel0,
   input logic [(1<<WIPER_W)-1:0]                    tap_sel1,
   input logic [1:0]                                 cmp_in,
   input logic [1:0]                                 cmp_out,
   input logic                                       recalled_q,
   input logic [NUM_TGT-1:0][DATA_W-1:0]             work_q,
   input logic [NUM_TGT-1:0][NUM_DR-1:0][DATA_W-1:0] dr_q
);
   localparam logic [WIPER_W-1:0] WTOP = '1;

   logic step0_up, step0_dn;
   assign step0_up = cmd_valid && recalled_q && cmd_op == OP_STEP &&
                     cmd_tgt == 2'd0 && cmd_data[0];
   assign step0_dn = cmd_valid && recalled_q && cmd_op == OP_STEP &&
                     cmd_tgt == 2'd0 && !cmd_data[0];

   a_r1_recall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recalled_q) |-> (work_q[0] == dr_q[0][0] && work_q[1] == dr_q[1][0] &&
                             work_q[2] == dr_q[2][0] && work_q[3] == dr_q[3][0]));

   a_r3_tap0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel0) == 1 && tap_sel0[wiper0_code]);

   a_r3_tap1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel1) == 1 && tap_sel1[wiper1_code]);

   a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step0_up && wiper0_code != WTOP) |=> wiper0_code == $past(wiper0_code) + 1'b1);

   a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step0_up && wiper0_code == WTOP) |=> wiper0_code == WTOP);

   a_r4_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (step0_dn && wiper0_code == '0) |=> wiper0_code == '0);

   a_r5_dr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(dr_q)));

   a_r6_wp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wp_n) |=> !busy);

   a_r11_hold0: assert property (@(posedge clk) disable iff (!rst_n)
      work_q[2][ACR_LATCH] |=> $stable(cmp_out[0]));

   a_r11_follow0: assert property (@(posedge clk) disable iff (!rst_n)
      !work_q[2][ACR_LATCH] |=> cmp_out[0] == $past(cmp_in[0]));

   a_r11_hold1: assert property (@(posedge clk) disable iff (!rst_n)
      work_q[3][ACR_LATCH] |=> $stable(cmp_out[1]));
endmodule

bind trim_regbank trim_regbank_chk #(.DATA_W(DATA_W), .WIPER_W(WIPER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_tgt(cmd_tgt), .cmd_data(cmd_data), .busy(busy),
   .wiper0_code(wiper0_code), .wiper1_code(wiper1_code),
   .tap_sel0(tap_sel0), .tap_sel1(tap_sel1), .cmp_in(cmp_in), .cmp_out(cmp_out),
   .recalled_q(recalled_q), .work_q(work_q), .dr_q(dr_q)
);

// File: tb/trim_regbank_tb.sv
`timescale 1ns/1ps
module trim_regbank_tb_top;
   localparam int BUSY = 20;
   localparam logic [3:0] RDW = 4'h1, WRW = 4'h2, RDD = 4'h3, WRD = 4'h4, LOAD = 4'h5,
                          SAVE = 4'h6, GLOAD = 4'h7, GSAVE = 4'h8, STEP = 4'h9, STAT = 4'hA;

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] tgt;
      logic [1:0] rsel;
      logic [5:0] data;
      logic       chk;
      logic [5:0] exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{RDW,  2'd0, 2'd0, 6'h00, 1'b1, 6'd1 },  // R1 wiper0 recalled
      '{RDW,  2'd3, 2'd0, 6'h00, 1'b1, 6'd25},  // R1 comparator 1 recalled
      '{WRW,  2'd0, 2'd0, 6'h3E, 1'b0, 6'd0 },  // R2
      '{STEP, 2'd0, 2'd0, 6'h01, 1'b0, 6'd0 },  // R4 up
      '{RDW,  2'd0, 2'd0, 6'h00, 1'b1, 6'h3F},  // R4
      '{STEP, 2'd0, 2'd0, 6'h01, 1'b0, 6'd0 },  // R4 up at top
      '{RDW,  2'd0, 2'd0, 6'h00, 1'b1, 6'h3F},  // R4 saturated
      '{WRW,  2'd1, 2'd0, 6'h00, 1'b0, 6'd0 },  // R2
      '{STEP, 2'd1, 2'd0, 6'h00, 1'b0, 6'd0 },  // R4 down at bottom
      '{RDW,  2'd1, 2'd0, 6'h00, 1'b1, 6'h00},  // R4 saturated
      '{STEP, 2'd2, 2'd0, 6'h01, 1'b0, 6'd0 },  // R4 ignored on target 2
      '{RDW,  2'd2, 2'd0, 6'h00, 1'b1, 6'd17},  // R4
      '{RDD,  2'd1, 2'd2, 6'h00, 1'b1, 6'd13},  // R1 reset image
      '{LOAD, 2'd1, 2'd3, 6'h00, 1'b0, 6'd0 },  // R8 load
      '{RDW,  2'd1, 2'd0, 6'h00, 1'b1, 6'd15}   // R8
   };
   localparam string VTAG [NV] = '{"R1","R1","R2","R4","R4","R4","R4","R2",
                                   "R4","R4","R4","R4","R1","R8","R8"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_n = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [1:0]  cmd_tgt = '0;
   logic [1:0]  cmd_reg = '0;
   logic [5:0]  cmd_data = '0;
   logic        rd_valid;
   logic [5:0]  rd_data;
   logic        busy;
   logic [5:0]  wiper0_code, wiper1_code;
   logic [63:0] tap_sel0, tap_sel1;
   logic [1:0]  cmp_in = '0;
   logic [1:0]  cmp_out, cmp_oe, cmp_pwr;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   trim_regbank #(.DATA_W(6), .WIPER_W(6), .BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_tgt(cmd_tgt), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
      .wiper0_code(wiper0_code), .wiper1_code(wiper1_code),
      .tap_sel0(tap_sel0), .tap_sel1(tap_sel1),
      .cmp_in(cmp_in), .cmp_out(cmp_out), .cmp_oe(cmp_oe), .cmp_pwr(cmp_pwr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [3:0] op, input logic [1:0] t, input logic [1:0] r,
                         input logic [5:0] d);
      cmd_op = op; cmd_tgt = t; cmd_reg = r; cmd_data = d; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [3:0] op, input logic [1:0] t,
                           input logic [1:0] r, input logic [5:0] exp);
      do_cmd(op, t, r, 6'h00);
      check(tag, {rd_valid, rd_data}, {1'b1, exp});
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset and recall state
      check("R1 rd_valid", rd_valid, 0);
      check("R5 busy idle", busy, 0);
      check("R1 wiper0", wiper0_code, 1);
      check("R1 wiper1", wiper1_code, 9);
      check("R3 tap0", tap_sel0, 64'h2);
      check("R11 pwr", cmp_pwr, 2'b11);
      check("R11 oe", cmp_oe, 2'b00);

      for (int i = 0; i < NV; i++) begin
         do_cmd(VEC[i].op, VEC[i].tgt, VEC[i].rsel, VEC[i].data);
         if (VEC[i].chk) check(VTAG[i], {rd_valid, rd_data}, {1'b1, VEC[i].exp});
      end

      // R3 rails of the tap decoder
      check("R3 tap0 top", tap_sel0, 64'h1 << 63);
      check("R3 tap1", tap_sel1, 64'h1 << 15);

      // R5 busy window length and commit
      do_cmd(WRD, 2'd0, 2'd1, 6'h2A);
      n = 0;
      while (busy) begin
         n++;
         @(posedge clk);
         @(negedge clk);
      end
      check("R5 busy cycles", n, BUSY);
      read_chk("R5 committed", RDD, 2'd0, 2'd1, 6'h2A);

      // R5 old value during window, R10 status, R7 dropped write
      do_cmd(WRD, 2'd0, 2'd1, 6'h15);
      read_chk("R5 old value", RDD, 2'd0, 2'd1, 6'h2A);
      read_chk("R10 status busy", STAT, 2'd0, 2'd0, 6'h01);
      do_cmd(WRD, 2'd0, 2'd2, 6'h3C);
      wait_idle();
      read_chk("R10 status idle", STAT, 2'd0, 2'd0, 6'h00);
      read_chk("R5 new value", RDD, 2'd0, 2'd1, 6'h15);
      read_chk("R7 dropped", RDD, 2'd0, 2'd2, 6'd5);

      // R6 write protect
      wp_n = 1'b0;
      do_cmd(WRD, 2'd1, 2'd0, 6'h30);
      check("R6 no busy wr", busy, 0);
      do_cmd(SAVE, 2'd1, 2'd0, 6'h00);
      check("R6 no busy save", busy, 0);
      wp_n = 1'b1;
      read_chk("R6 unchanged", RDD, 2'd1, 2'd0, 6'd9);

      // R8 save one working register
      do_cmd(SAVE, 2'd1, 2'd0, 6'h00);
      wait_idle();
      read_chk("R8 saved", RDD, 2'd1, 2'd0, 6'd15);

      // R9 global save and load
      do_cmd(GSAVE, 2'd0, 2'd3, 6'h00);
      wait_idle();
      for (int t = 0; t < 4; t++) do_cmd(WRW, 2'(t), 2'd0, 6'h00);
      check("R2 cleared", wiper0_code, 0);
      do_cmd(GLOAD, 2'd0, 2'd3, 6'h00);
      check("R9 wiper0", wiper0_code, 6'h3F);
      check("R9 wiper1", wiper1_code, 6'd15);
      read_chk("R9 target3", RDW, 2'd3, 2'd0, 6'd25);
      read_chk("R9 stored t2", RDD, 2'd2, 2'd3, 6'd17);

      // R11 comparator controls
      cmp_in = 2'b01;
      do_cmd(WRW, 2'd2, 2'd0, 6'h03);
      check("R11 oe on", cmp_oe[0], 1);
      check("R11 follow", cmp_out[0], 1);
      do_cmd(WRW, 2'd2, 2'd0, 6'h07);
      cmp_in = 2'b00;
      repeat (3) @(negedge clk);
      check("R11 held", cmp_out[0], 1);
      do_cmd(WRW, 2'd2, 2'd0, 6'h03);
      check("R11 hold edge", cmp_out[0], 1);
      @(negedge clk);
      check("R11 released", cmp_out[0], 0);
      do_cmd(WRW, 2'd2, 2'd0, 6'h00);
      check("R11 pwr off", cmp_pwr[0], 0);
      check("R11 oe off", cmp_oe[0], 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule